// File: doc/BRIEF.md
# Chained Transmit Descriptor Engine

This block is the transmit half of a descriptor-driven DMA controller. Software builds a linked list of four-word descriptors in memory, hands each one over by setting its ownership flag, and points the engine at the first one. The engine reads a descriptor through a word-addressed memory port. If the engine owns the descriptor, it streams the referenced buffer one byte at a time over a valid/ready interface. It then writes back a status word that hands the descriptor back to software, and moves on to the next descriptor.

When the engine reaches a descriptor it does not own, it parks in a suspended state. A poll pulse makes it read that same descriptor again. A level-sensitive run input starts the engine from a base address. Dropping run stops the engine, but only after the frame in flight has been fully sent and written back. A sticky interrupt flag reports completion of descriptors that ask for it. Frame framing, CRC and the line interface belong to downstream logic.

Top module: `tdx_engine`

## Requirements
- R1: After reset, `stopped` is 1 and `suspended`, `tx_valid`, `irq_done` and `mem_req` are all 0 while `run` stays low.
- R2: When `run` is high while stopped, the engine loads `base_addr` as the current descriptor and reads its word 0. It processes the descriptor only if bit 31 of word 0 is 1; otherwise it raises `suspended`.
- R3: A descriptor occupies four consecutive words at byte offsets +0, +4, +8 and +12: status, control, buffer byte address and next pointer. The control word fields are bit 31 (interrupt on completion), bit 30 (last segment), bit 29 (first segment), bit 24 (chained) and bits 10:0 (byte length).
- R4: The engine streams exactly `length` bytes starting at the buffer byte address. The address may have any alignment. The byte at address a is taken from bits 8*(a mod 4)+7 down to 8*(a mod 4) of memory word a/4. A length of 0 streams nothing.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_first`, `tx_last` and `tx_valid` hold their values.
- R6: `tx_first` marks the first byte only when the first-segment bit is set. `tx_last` marks the final byte only when the last-segment bit is set.
- R7: On completion the engine writes word 0 with bit 31 cleared. The error flags `err_flags[3]`, `err_flags[2]`, `err_flags[1]` and `err_flags[0]` are copied to bits 14, 9, 8 and 1. Bit 15 is the OR of all error bits, and every other bit is 0.
- R8: A length above MAX_FRAME (1514) streams no bytes. Its status word carries bit 0 and bit 15 with bit 31 cleared.
- R9: With the chained bit set, the next descriptor address is word 3. With the chained bit clear, it is the current address plus 16, and word 3 is ignored.
- R10: While suspended and running, the engine stays suspended until `poll` pulses. A poll makes it re-read word 0 of the same descriptor. If that descriptor is still not owned, no byte is streamed.
- R11: `irq_done` is set when a descriptor with the interrupt bit completes, holds until an `irq_clr` pulse, and is not set by descriptors without the bit.
- R12: If `run` falls during a frame, the frame is finished and written back. The engine then reports `stopped` without touching the next descriptor. Raising `run` again restarts from `base_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start/stop level |
| poll | input | 1 | Poll-demand pulse |
| base_addr | input | AW+2 | Byte address of first descriptor |
| err_flags | input | 4 | Jabber, late collision, excess collisions, underrun for current frame |
| irq_clr | input | 1 | Write-one clear of interrupt flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Byte accepted |
| tx_data | output | 8 | Byte |
| tx_first | output | 1 | First byte of a first segment |
| tx_last | output | 1 | Final byte of a last segment |
| irq_done | output | 1 | Sticky completion flag |
| suspended | output | 1 | Parked on a descriptor not owned |
| stopped | output | 1 | Halted by run low |

## Verification
The bench sweeps lengths 0 to 9 over all four buffer alignments, with and without back-pressure. A design that fetched a word only once per frame, or at the wrong lane boundary, would repeat or skip bytes; one that mishandled length 0 would underflow its counter and stream a very long burst. An unchained descriptor whose word 3 points at an owned decoy catches a design that always follows the pointer, since the decoy's bytes would appear. The run-drop test stops mid-buffer with the next descriptor already owned. A design that halted at once would leave a short frame and an owned status word, and one that ignored the stop would consume the second frame.

// File: rtl/tdx_pkg.sv
package tdx_pkg;

   typedef enum logic [3:0] {
      S_STOP, S_RD0, S_W0, S_RD1, S_W1, S_RD2, S_W2, S_RD3, S_W3,
      S_BRD, S_BW, S_STRM, S_WB, S_SUSP
   } tdx_state_e;

   localparam int OWN_BIT     = 31;
   localparam int IC_BIT      = 31;
   localparam int LS_BIT      = 30;
   localparam int FS_BIT      = 29;
   localparam int CH_BIT      = 24;
   localparam int DESC_BYTES  = 16;

   typedef struct packed {
      logic ic;
      logic ls;
      logic fs;
      logic ch;
   } tdx_ctl_t;

endpackage

// File: rtl/tdx_lane_pick.sv
module tdx_lane_pick #(
   parameter int BYTES = 4,
   localparam int SEL_W = $clog2(BYTES)
) (
   input  logic [8*BYTES-1:0] word,
   input  logic [SEL_W-1:0]   sel,
   output logic [7:0]         byte_o
);

   logic [7:0] lanes [BYTES];

   generate
      if (BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
         $error("tdx_lane_pick: BYTES must be a power of two >= 2");
      end
      for (genvar i = 0; i < BYTES; i++) begin : g_lane
         assign lanes[i] = word[8*i +: 8];
      end
   endgenerate

   assign byte_o = lanes[sel];

endmodule

// File: rtl/tdx_sticky.sv
module tdx_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   // R11: flag holds until cleared
   a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag);

endmodule

// File: rtl/tdx_status_pack.sv
module tdx_status_pack (
   input  logic [3:0]  err,        // [3] jabber [2] late [1] excess [0] underrun
   input  logic        len_fault,
   output logic [31:0] status
);

   logic summary;
   assign summary = (|err) | len_fault;

   // owner bit cleared; field positions are what software decodes
   assign status = {1'b0, 15'd0, summary, err[3], 4'd0, err[2], err[1],
                    6'd0, err[0], len_fault};

endmodule

// File: rtl/tdx_engine.sv
module tdx_engine
   import tdx_pkg::*;
#(
   parameter int AW        = 16,
   parameter int LEN_W     = 11,
   parameter int MAX_FRAME = 1514,
   localparam int BA_W     = AW + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            poll,
   input  logic [BA_W-1:0] base_addr,
   input  logic [3:0]      err_flags,
   input  logic            irq_clr,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [31:0]     mem_wdata,
   input  logic            mem_rvalid,
   input  logic [31:0]     mem_rdata,
   output logic            tx_valid,
   input  logic            tx_ready,
   output logic [7:0]      tx_data,
   output logic            tx_first,
   output logic            tx_last,
   output logic            irq_done,
   output logic            suspended,
   output logic            stopped
);

   localparam logic [LEN_W-1:0] MAXL   = LEN_W'(MAX_FRAME);
   localparam logic [BA_W-1:0]  STRIDE = BA_W'(DESC_BYTES);

   generate
      if (AW < 4 || AW > 30) begin : g_bad_aw
         $error("tdx_engine: AW out of range");
      end
      if (LEN_W < 2 || LEN_W > 24) begin : g_bad_len
         $error("tdx_engine: LEN_W out of range");
      end
      if (MAX_FRAME < 1 || MAX_FRAME >= (1 << LEN_W)) begin : g_bad_max
         $error("tdx_engine: MAX_FRAME must fit the length field");
      end
   endgenerate

   tdx_state_e       st;
   logic [BA_W-1:0]  cur_q, nxt_q, bufp_q;
   tdx_ctl_t         ctl_q;
   logic [LEN_W-1:0] len_q, cnt_q;
   logic [31:0]      word_q;
   logic             first_q;
   logic             oversize;
   logic [AW-1:0]    cur_w;
   logic [31:0]      status_w;
   logic             rd_unused;

   assign oversize  = len_q > MAXL;
   assign cur_w     = cur_q[BA_W-1:2];
   assign rd_unused = ^mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_STOP;
         cur_q   <= '0;
         nxt_q   <= '0;
         bufp_q  <= '0;
         ctl_q   <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         word_q  <= '0;
         first_q <= 1'b0;
      end else begin
         unique case (st)
            S_STOP: if (run) begin
               cur_q <= base_addr;
               st    <= S_RD0;
            end
            S_RD0: st <= S_W0;
            S_W0: if (mem_rvalid) st <= mem_rdata[OWN_BIT] ? S_RD1 : S_SUSP;
            S_SUSP: begin
               if (!run)      st <= S_STOP;
               else if (poll) st <= S_RD0;
            end
            S_RD1: st <= S_W1;
            S_W1: if (mem_rvalid) begin
               ctl_q <= '{ic: mem_rdata[IC_BIT], ls: mem_rdata[LS_BIT],
                          fs: mem_rdata[FS_BIT], ch: mem_rdata[CH_BIT]};
               len_q <= mem_rdata[LEN_W-1:0];
               st    <= S_RD2;
            end
            S_RD2: st <= S_W2;
            S_W2: if (mem_rvalid) begin
               bufp_q <= mem_rdata[BA_W-1:0];
               st     <= S_RD3;
            end
            S_RD3: st <= S_W3;
            S_W3: if (mem_rvalid) begin
               nxt_q   <= ctl_q.ch ? mem_rdata[BA_W-1:0] : cur_q + STRIDE;
               cnt_q   <= len_q;
               first_q <= 1'b1;
               st      <= (len_q == '0 || oversize) ? S_WB : S_BRD;
            end
            S_BRD: st <= S_BW;
            S_BW: if (mem_rvalid) begin
               word_q <= mem_rdata;
               st     <= S_STRM;
            end
            S_STRM: if (tx_ready) begin
               first_q <= 1'b0;
               bufp_q  <= bufp_q + 1'b1;
               cnt_q   <= cnt_q - 1'b1;
               if (cnt_q == LEN_W'(1))    st <= S_WB;
               else if (&bufp_q[1:0])     st <= S_BRD;
            end
            S_WB: begin
               cur_q <= nxt_q;
               st    <= run ? S_RD0 : S_STOP;
            end
            default: st <= S_STOP;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = cur_w;
      unique case (st)
         S_RD0: mem_req = 1'b1;
         S_RD1: begin mem_req = 1'b1; mem_addr = cur_w + AW'(1); end
         S_RD2: begin mem_req = 1'b1; mem_addr = cur_w + AW'(2); end
         S_RD3: begin mem_req = 1'b1; mem_addr = cur_w + AW'(3); end
         S_BRD: begin mem_req = 1'b1; mem_addr = bufp_q[BA_W-1:2]; end
         S_WB:  begin mem_req = 1'b1; mem_we = 1'b1; end
         default: ;
      endcase
   end

   tdx_status_pack u_status (
      .err       (err_flags),
      .len_fault (oversize),
      .status    (status_w)
   );
   assign mem_wdata = status_w;

   tdx_lane_pick #(.BYTES(4)) u_lane (
      .word   (word_q),
      .sel    (bufp_q[1:0]),
      .byte_o (tx_data)
   );

   tdx_sticky u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (st == S_WB && ctl_q.ic),
      .clr   (irq_clr),
      .flag  (irq_done)
   );

   assign tx_valid  = (st == S_STRM);
   assign tx_first  = tx_valid && first_q && ctl_q.fs;
   assign tx_last   = tx_valid && (cnt_q == LEN_W'(1)) && ctl_q.ls;
   assign suspended = (st == S_SUSP);
   assign stopped   = (st == S_STOP);

   // R7: a write-back never hands ownership back to the engine
   a_r7_owner_released: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_wdata[OWN_BIT]);

   // R5: offered byte is stable until accepted
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)
                                && $stable(tx_first) && $stable(tx_last));

   // R8: no byte of an oversized frame reaches the stream
   a_r8_no_oversize: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !oversize);

   // R10: suspension persists without a poll
   a_r10_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      suspended && run && !poll |=> suspended);

   // R12: stopped engine stays quiet
   a_r12_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      stopped && !run |=> stopped && !mem_req);

   // R12: a frame in progress is never abandoned when run falls
   a_r12_frame_finish: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !run |=> tx_valid || mem_req);

endmodule

// File: tb/tdx_engine_test.sv
`timescale 1ns/1ps
module tdx_engine_test;

   localparam int AW   = 10;
   localparam int BA_W = AW + 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            run = 1'b0, poll = 1'b0, irq_clr = 1'b0;
   logic [BA_W-1:0] base_addr = '0;
   logic [3:0]      err_flags = '0;
   logic            mem_req, mem_we, mem_rvalid;
   logic [AW-1:0]   mem_addr;
   logic [31:0]     mem_wdata, mem_rdata;
   logic            tx_valid, tx_ready, tx_first, tx_last;
   logic [7:0]      tx_data;
   logic            irq_done, suspended, stopped;

   tdx_engine #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .base_addr(base_addr),
      .err_flags(err_flags), .irq_clr(irq_clr), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_data(tx_data), .tx_first(tx_first),
      .tx_last(tx_last), .irq_done(irq_done), .suspended(suspended),
      .stopped(stopped));

   function automatic logic [7:0] pat(input logic [BA_W-1:0] b);
      logic [15:0] t;
      t = 16'(b) * 16'd13 + 16'd5;
      return t[7:0];
   endfunction

   function automatic logic [31:0] ctl(input bit ic, ls, fs, ch, input int len);
      logic [10:0] l;
      l = 11'(len);
      return {ic, ls, fs, 4'd0, ch, 13'd0, l};
   endfunction

   // memory model: one-cycle read latency, host poke port
   logic [31:0]   mem [0:1023];
   logic          h_we = 1'b0;
   logic [AW-1:0] h_addr = '0;
   logic [31:0]   h_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++)
            mem[i] <= (i < 256) ? 32'd0 :
               {pat(12'(4*i+3)), pat(12'(4*i+2)), pat(12'(4*i+1)), pat(12'(4*i))};
         mem_rvalid <= 1'b0;
         mem_rdata  <= '0;
      end else begin
         mem_rvalid <= mem_req && !mem_we;
         mem_rdata  <= mem[mem_addr];
         if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
         else if (h_we)         mem[h_addr]   <= h_data;
      end
   end

   // back-pressure
   bit bp = 1'b0;
   int cyc = 0;
   initial tx_ready = 1'b1;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      tx_ready <= bp ? (cyc % 3 != 0) : 1'b1;
   end

   // capture of accepted bytes
   logic [7:0] cap  [0:2047];
   bit         capf [0:2047];
   bit         capl [0:2047];
   int         ncap = 0;
   bit         clr_cap = 1'b0;
   always @(posedge clk) begin
      if (clr_cap) ncap <= 0;
      else if (rst_n && tx_valid && tx_ready) begin
         if (ncap < 2048) begin
            cap[ncap]  <= tx_data;
            capf[ncap] <= tx_first;
            capl[ncap] <= tx_last;
         end
         ncap <= ncap + 1;
      end
   end

   int nchk = 0, nerr = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 190000) begin
         nerr++;
         $display("FAIL watchdog: actual=%0d expected=<190000", wd);
         $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
         $finish;
      end
   end

   task automatic poke(input logic [BA_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      h_we = 1'b1; h_addr = a[BA_W-1:2]; h_data = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   task automatic set_desc(input logic [BA_W-1:0] a, input logic [31:0] c,
                           input logic [BA_W-1:0] b, nx, input bit own);
      poke(a + 12'd4,  c);
      poke(a + 12'd8,  32'(b));
      poke(a + 12'd12, 32'(nx));
      poke(a, {own, 31'd0});
   endtask

   task automatic clear_cap();
      @(negedge clk); clr_cap = 1'b1;
      @(negedge clk); clr_cap = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      @(negedge clk);
      while (!(suspended || stopped) && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 20000) chk(1'b0, {req, " timeout"}, 32'(n), 0);
   endtask

   task automatic pulse_poll();
      @(negedge clk); poll = 1'b1;
      @(negedge clk); poll = 1'b0;
   endtask

   task automatic kick(input string req);
      pulse_poll();
      wait_idle(req);
   endtask

   task automatic chk_frame(input int s, input logic [BA_W-1:0] b, input int len,
                            input bit fs, ls, input string req);
      int bad = 0;
      for (int i = 0; i < len; i++) begin
         if (cap[s+i] !== pat(b + 12'(i))) bad++;
         if (capf[s+i] !== (fs && i == 0)) bad++;
         if (capl[s+i] !== (ls && i == len-1)) bad++;
      end
      chk(bad == 0, req, 32'(bad), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(stopped === 1'b1,   "R1 stopped",   32'(stopped),   1);
      chk(suspended === 1'b0, "R1 suspended", 32'(suspended), 0);
      chk(tx_valid === 1'b0,  "R1 tx_valid",  32'(tx_valid),  0);
      chk(irq_done === 1'b0,  "R1 irq",       32'(irq_done),  0);
      chk(mem_req === 1'b0,   "R1 mem_req",   32'(mem_req),   0);

      // chain: D0 -> D1 (chained), D2 unchained with decoy pointer
      set_desc(12'h000, ctl(1,0,1,1,5), 12'h401, 12'h080, 1'b1);
      set_desc(12'h080, ctl(0,1,0,1,3), 12'h40B, 12'h0C0, 1'b1);
      set_desc(12'h0C0, ctl(0,1,1,0,1), 12'h413, 12'h300, 1'b1);
      set_desc(12'h300, ctl(0,1,1,1,2), 12'h480, 12'h300, 1'b1);
      base_addr = 12'h000;
      @(negedge clk); run = 1'b1;
      wait_idle("R2 start");
      chk(suspended === 1'b1, "R2 suspend on unowned", 32'(suspended), 1);
      chk(ncap == 9, "R9 unchained ignores word 3 (byte count)", 32'(ncap), 9);
      chk_frame(0, 12'h401, 5, 1, 0, "R4 R6 frame D0 unaligned");
      chk_frame(5, 12'h40B, 3, 0, 1, "R3 R6 frame D1");
      chk_frame(8, 12'h413, 1, 1, 1, "R4 frame D2 single byte");
      chk(mem[0] == 32'h0,    "R7 D0 writeback", mem[0], 0);
      chk(mem[8'h20] == 32'h0, "R7 D1 writeback", mem[8'h20], 0);
      chk(mem[8'h30] == 32'h0, "R7 D2 writeback", mem[8'h30], 0);
      chk(mem[8'hC0] == 32'h8000_0000, "R9 decoy untouched", mem[8'hC0], 32'h8000_0000);
      chk(irq_done === 1'b1, "R11 irq set", 32'(irq_done), 1);

      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk(irq_done === 1'b0, "R11 irq cleared", 32'(irq_done), 0);

      // poll with descriptor at 0x0D0 still not owned
      clear_cap();
      kick("R10 poll unowned");
      repeat (5) @(negedge clk);
      chk(suspended === 1'b1 && ncap == 0, "R10 stays suspended", 32'(ncap), 0);

      // error flag mapping
      set_desc(12'h0D0, ctl(0,1,1,1,2), 12'h420, 12'h0E0, 1'b1);
      err_flags = 4'b1001;
      kick("R7 err a");
      chk(mem[8'h34] == 32'h0000_C002, "R7 status jabber+underrun", mem[8'h34], 32'h0000_C002);
      chk_frame(0, 12'h420, 2, 1, 1, "R4 err frame a");
      set_desc(12'h0E0, ctl(0,1,1,1,2), 12'h430, 12'h0F0, 1'b1);
      err_flags = 4'b0110;
      kick("R7 err b");
      chk(mem[8'h38] == 32'h0000_8300, "R7 status late+excess", mem[8'h38], 32'h0000_8300);
      chk(irq_done === 1'b0, "R11 no irq without bit", 32'(irq_done), 0);
      err_flags = 4'b0000;

      // sweep of length and alignment, self-chained at 0x0F0
      for (int len = 0; len <= 9; len++) begin
         for (int off = 0; off < 4; off++) begin
            logic [BA_W-1:0] b;
            b = 12'h500 + 12'(off) + 12'(len * 16);
            bp = off[0];
            clear_cap();
            set_desc(12'h0F0, ctl(0,1,1,1,len), b, 12'h0F0, 1'b1);
            kick("R4 sweep");
            chk(ncap == len, "R4 sweep byte count", 32'(ncap), 32'(len));
            chk_frame(0, b, len, 1, 1, "R4 R5 sweep bytes");
            chk(mem[8'h3C] == 32'h0, "R7 sweep writeback", mem[8'h3C], 0);
         end
      end
      bp = 1'b0;

      // oversize and maximum
      clear_cap();
      set_desc(12'h0F0, ctl(0,1,1,1,1515), 12'h600, 12'h0F0, 1'b1);
      kick("R8 oversize");
      chk(ncap == 0, "R8 oversize streams nothing", 32'(ncap), 0);
      chk(mem[8'h3C] == 32'h0000_8001, "R8 oversize status", mem[8'h3C], 32'h0000_8001);
      clear_cap();
      set_desc(12'h0F0, ctl(0,1,1,1,1514), 12'h600, 12'h0F0, 1'b1);
      kick("R8 maximum");
      chk(ncap == 1514, "R8 maximum byte count", 32'(ncap), 1514);
      chk_frame(0, 12'h600, 1514, 1, 1, "R8 maximum bytes");
      chk(mem[8'h3C] == 32'h0, "R8 maximum status", mem[8'h3C], 0);

      // stop during a buffer with next descriptor owned
      clear_cap();
      bp = 1'b1;
      set_desc(12'h100, ctl(0,1,1,1,4),  12'h740, 12'h100, 1'b1);
      set_desc(12'h0F0, ctl(1,1,1,1,40), 12'h700, 12'h100, 1'b1);
      pulse_poll();
      begin
         int n = 0;
         while (ncap < 5 && n < 2000) begin @(negedge clk); n++; end
      end
      run = 1'b0;
      wait_idle("R12 stop");
      chk(stopped === 1'b1, "R12 stopped", 32'(stopped), 1);
      chk(ncap == 40, "R12 frame completed", 32'(ncap), 40);
      chk_frame(0, 12'h700, 40, 1, 1, "R12 frame bytes");
      chk(mem[8'h3C] == 32'h0, "R12 writeback done", mem[8'h3C], 0);
      chk(mem[8'h40] == 32'h8000_0000, "R12 next untouched", mem[8'h40], 32'h8000_0000);
      chk(irq_done === 1'b1, "R11 irq on stopped frame", 32'(irq_done), 1);
      bp = 1'b0;

      // restart from a new base
      base_addr = 12'h100;
      @(negedge clk); run = 1'b1;
      wait_idle("R12 restart");
      chk(ncap == 44, "R12 restart byte count", 32'(ncap), 44);
      chk_frame(40, 12'h740, 4, 1, 1, "R2 restart frame");
      chk(mem[8'h40] == 32'h0, "R12 restart writeback", mem[8'h40], 0);
      chk(suspended === 1'b1, "R10 suspended after restart", 32'(suspended), 1);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule